// File: doc/BRIEF.md
# Fixed-Disk Adapter Status Handshake Registers

This block is the host-facing register pair of a small fixed-disk adapter. A host bus presents an address with a read or a write strobe. Two addresses are decoded. The control address takes a control byte on write and returns the adapter status byte on read. The attention address takes an attention nibble on write and returns the interrupt-status byte on read.

Writes move the status byte through a short handshake. A control byte with its top bit set raises the acknowledge bit (bit 1) of status. An attention write with a nonzero upper nibble replaces the whole status byte with the busy code 0x14. Reading interrupt status clears its bit 1, once per read strobe, so software sees each interrupt once. A side input ORs bits into interrupt status, so the adapter's engine, or a testbench, can raise interrupts. Data transfer, the drive interface and command execution belong to other blocks.

Top module: `dskhs_top`

## Requirements
- R1: A write to the control address (default 0x322) stores all 8 bits of wr_data as the control byte, visible on ctrl_o after the clock edge. A read of the control address returns the status byte on rd_data in the same cycle.
- R2: A control write with wr_data bit 7 set sets status bit 1 and keeps the other status bits. A control write with bit 7 clear leaves status unchanged.
- R3: A write to the attention address (default 0x324) stores wr_data AND 0xF0 as the attention byte, visible on attn_o. The lower nibble is dropped.
- R4: An attention write whose upper nibble is nonzero sets the status byte to 0x14. An attention write with a zero upper nibble leaves status unchanged.
- R5: A read of the attention address returns interrupt status on rd_data in the strobe cycle. At the clock edge that ends the first cycle of the strobe, bit 1 of interrupt status clears and the other bits are kept.
- R6: The clear happens once per read strobe. When rd_en stays high on the attention address for several consecutive cycles, only the first edge clears bit 1.
- R7: irq_set bits are ORed into interrupt status at each clock edge. When irq_set bit 1 is high at the same edge as a read-clear, bit 1 stays set.
- R8: An active-low reset clears the status, interrupt-status, attention and control bytes to zero.
- R9: A read of any other address returns 0xFF. rd_data is 0x00 while rd_en is low. A write to any other address changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (16) | Host port address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| irq_set | input | 8 | Bits ORed into interrupt status |
| rd_data | output | 8 | Read data, combinational in the strobe cycle |
| ctrl_o | output | 8 | Stored control byte |
| attn_o | output | 8 | Stored attention byte |

## Verification
On every cycle, the assertions check the effect of a single write: the control byte captured, status bit 1 raised, the masked attention byte, and the busy code loaded. They also check that a first-cycle interrupt read clears bit 1, that set bits always land, and that a control read returns status. Some behaviours only the bench scenarios can show. These are the orderings: status kept by a zero-nibble attention write, a held read strobe that clears only once while a set arrives mid-strobe, and unmapped accesses that leave every register unchanged. Reset to zero in the middle of a run is also a bench scenario.

// File: rtl/dskhs_pkg.sv
package dskhs_pkg;
    localparam int DATA_W = 8;

    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        byte_t status;
        byte_t irq;
        byte_t attn;
        byte_t ctrl;
    } regs_t;

    localparam byte_t ATTN_MASK  = 8'hF0;
    localparam byte_t BUSY_CODE  = 8'h14;
    localparam byte_t UNMAPPED   = 8'hFF;
    localparam int    ACK_BIT    = 1;
    localparam int    CLR_BIT    = 1;
    localparam int    GO_BIT     = 7;
endpackage

// File: rtl/dskhs_decode.sv
module dskhs_decode #(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CTRL_PORT = 16'h0322,
    parameter logic [ADDR_W-1:0] IRQ_PORT  = 16'h0324
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic              wr_ctrl,
    output logic              wr_attn,
    output logic              rd_ctrl,
    output logic              rd_irq
);
    logic hit_ctrl;
    logic hit_irq;

    always_comb begin
        hit_ctrl = (addr == CTRL_PORT);
        hit_irq  = (addr == IRQ_PORT);
        wr_ctrl  = wr_en & hit_ctrl;
        wr_attn  = wr_en & hit_irq;
        rd_ctrl  = rd_en & hit_ctrl;
        rd_irq   = rd_en & hit_irq;
    end
endmodule

// File: rtl/dskhs_strobe.sv
module dskhs_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic first,
    output logic prev_q
);
    logic prev_d;

    always_comb begin
        prev_d = level;
        first  = level & ~prev_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/dskhs_rdmux.sv
module dskhs_rdmux
    import dskhs_pkg::*;
(
    input  logic  rd_en,
    input  logic  rd_ctrl,
    input  logic  rd_irq,
    input  byte_t status,
    input  byte_t irq,
    output byte_t rd_data
);
    always_comb begin
        if (!rd_en)       rd_data = '0;
        else if (rd_ctrl) rd_data = status;
        else if (rd_irq)  rd_data = irq;
        else              rd_data = UNMAPPED;
    end
endmodule

// File: rtl/dskhs_top.sv
module dskhs_top
    import dskhs_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CTRL_PORT = 16'h0322,
    parameter logic [ADDR_W-1:0] IRQ_PORT  = 16'h0324
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wr_data,
    input  logic [7:0]        irq_set,
    output logic [7:0]        rd_data,
    output logic [7:0]        ctrl_o,
    output logic [7:0]        attn_o
);
    regs_t regs_d, regs_q;
    logic  wr_ctrl, wr_attn, rd_ctrl, rd_irq;
    logic  rd_first, rd_prev;
    byte_t attn_val;

    dskhs_decode #(
        .ADDR_W   (ADDR_W),
        .CTRL_PORT(CTRL_PORT),
        .IRQ_PORT (IRQ_PORT)
    ) u_decode (
        .addr   (bus_addr),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .wr_ctrl(wr_ctrl),
        .wr_attn(wr_attn),
        .rd_ctrl(rd_ctrl),
        .rd_irq (rd_irq)
    );

    dskhs_strobe u_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .level (rd_irq),
        .first (rd_first),
        .prev_q(rd_prev)
    );

    dskhs_rdmux u_rdmux (
        .rd_en  (rd_en),
        .rd_ctrl(rd_ctrl),
        .rd_irq (rd_irq),
        .status (regs_q.status),
        .irq    (regs_q.irq),
        .rd_data(rd_data)
    );

    // Next-state: writes, one-shot read clear, then set (set has priority)
    always_comb begin
        regs_d   = regs_q;
        attn_val = wr_data & ATTN_MASK;
        if (wr_ctrl) begin
            regs_d.ctrl = wr_data;
            if (wr_data[GO_BIT]) regs_d.status[ACK_BIT] = 1'b1;
        end
        if (wr_attn) begin
            regs_d.attn = attn_val;
            if (|attn_val) regs_d.status = BUSY_CODE;
        end
        if (rd_first) regs_d.irq[CLR_BIT] = 1'b0;
        regs_d.irq = regs_d.irq | irq_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign ctrl_o = regs_q.ctrl;
    assign attn_o = regs_q.attn;
endmodule

// File: rtl/dskhs_checker.sv
module dskhs_checker
    import dskhs_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CTRL_PORT = 16'h0322,
    parameter logic [ADDR_W-1:0] IRQ_PORT  = 16'h0324
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [7:0]        wr_data,
    input logic [7:0]        irq_set,
    input logic [7:0]        rd_data,
    input logic [7:0]        ctrl_o,
    input logic [7:0]        attn_o,
    input logic [7:0]        status,
    input logic [7:0]        irq,
    input logic              rd_prev
);
    logic wc, wa, ri;
    assign wc = wr_en && (bus_addr == CTRL_PORT);
    assign wa = wr_en && (bus_addr == IRQ_PORT);
    assign ri = rd_en && (bus_addr == IRQ_PORT);

    p_ctrl_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wc |=> ctrl_o == $past(wr_data));

    p_status_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_addr == CTRL_PORT) |-> rd_data == status);

    p_ack_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wc && wr_data[7]) |=> status[1]);

    p_attn_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wa |=> attn_o == ($past(wr_data) & 8'hF0));

    p_busy_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wa && (wr_data[7:4] != 4'h0)) |=> status == 8'h14);

    p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ri && !rd_prev && !irq_set[1]) |=> !irq[1]);

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_set != 8'h00) |=> ((irq & $past(irq_set)) == $past(irq_set)));

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rd_data == 8'h00);
endmodule

bind dskhs_top dskhs_checker #(
    .ADDR_W   (ADDR_W),
    .CTRL_PORT(CTRL_PORT),
    .IRQ_PORT (IRQ_PORT)
) u_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_addr(bus_addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wr_data (wr_data),
    .irq_set (irq_set),
    .rd_data (rd_data),
    .ctrl_o  (ctrl_o),
    .attn_o  (attn_o),
    .status  (regs_q.status),
    .irq     (regs_q.irq),
    .rd_prev (rd_prev)
);

// File: tb/dskhs_top_tb_top.sv
module dskhs_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] CP = 16'h0322;
    localparam logic [15:0] IP = 16'h0324;
    localparam logic [15:0] XP = 16'h0100;

    // kind: 1 = write (check ctrl_o, or attn_o at IP), 2 = read (check rd_data), 3 = set pulse
    typedef struct packed {
        logic [1:0]  kind;
        logic [15:0] addr;
        logic [7:0]  data;
        logic [7:0]  exp;
        logic [7:0]  tag;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{2'd1, CP, 8'h05, 8'h05, 8'd1},  // R1 control store
        '{2'd2, CP, 8'h00, 8'h00, 8'd2},  // R2 bit7 clear: status unchanged
        '{2'd1, CP, 8'h80, 8'h80, 8'd1},  // R1
        '{2'd2, CP, 8'h00, 8'h02, 8'd2},  // R2 ack bit raised
        '{2'd1, IP, 8'h0F, 8'h00, 8'd3},  // R3 lower nibble dropped
        '{2'd2, CP, 8'h00, 8'h02, 8'd4},  // R4 zero nibble keeps status
        '{2'd1, IP, 8'hA7, 8'hA0, 8'd3},  // R3 mask
        '{2'd2, CP, 8'h00, 8'h14, 8'd4},  // R4 busy code
        '{2'd1, CP, 8'h81, 8'h81, 8'd1},  // R1
        '{2'd2, CP, 8'h00, 8'h16, 8'd2},  // R2 other bits kept
        '{2'd3, IP, 8'h0A, 8'h00, 8'd7},  // R7 set bits 1 and 3
        '{2'd2, IP, 8'h00, 8'h0A, 8'd5},  // R5 read returns
        '{2'd2, IP, 8'h00, 8'h08, 8'd5},  // R5 bit1 cleared, bit3 kept
        '{2'd2, XP, 8'h00, 8'hFF, 8'd9},  // R9 unmapped read
        '{2'd1, XP, 8'h55, 8'h81, 8'd9},  // R9 unmapped write: ctrl kept
        '{2'd2, CP, 8'h00, 8'h16, 8'd9}   // R9 status kept
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  irq_set = '0;
    logic [7:0]  rd_data, ctrl_o, attn_o;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dskhs_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en),
        .rd_en(rd_en), .wr_data(wr_data), .irq_set(irq_set),
        .rd_data(rd_data), .ctrl_o(ctrl_o), .attn_o(attn_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; rd_en = 0; irq_set = '0; bus_addr = '0; wr_data = '0;
    endtask

    // one access; read data sampled mid-cycle, write results after the edge
    task automatic do_read(input logic [15:0] a, output logic [7:0] v);
        @(negedge clk); bus_addr = a; rd_en = 1; #1 v = rd_data;
        @(negedge clk); idle();
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; wr_en = 1; wr_data = d;
        @(negedge clk); idle();
    endtask

    task automatic do_set(input logic [7:0] s);
        @(negedge clk); irq_set = s;
        @(negedge clk); idle();
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
    endtask

    task automatic reset_checks(input string req);
        logic [7:0] v;
        check(req, ctrl_o, 8'h00);
        check(req, attn_o, 8'h00);
        do_read(CP, v); check(req, v, 8'h00);
        do_read(IP, v); check(req, v, 8'h00);
    endtask

    initial begin
        logic [7:0] v;
        do_reset();
        reset_checks("R8 reset");

        for (int i = 0; i < NV; i++) begin
            string tg;
            tg = $sformatf("R%0d vec%0d", VECS[i].tag, i);
            case (VECS[i].kind)
                2'd1: begin
                    do_write(VECS[i].addr, VECS[i].data);
                    check(tg, (VECS[i].addr == IP) ? attn_o : ctrl_o, VECS[i].exp);
                end
                2'd2: begin
                    do_read(VECS[i].addr, v);
                    check(tg, v, VECS[i].exp);
                end
                default: do_set(VECS[i].data);
            endcase
        end

        // R9: idle read data is zero
        @(negedge clk); #1 check("R9 idle", rd_data, 8'h00);

        // R7: set coinciding with read-clear keeps bit1
        do_set(8'h02);
        @(negedge clk); bus_addr = IP; rd_en = 1; irq_set = 8'h02;
        #1 check("R7 read value", rd_data, 8'h0A);
        @(negedge clk); idle();
        do_read(IP, v); check("R7 set wins", v, 8'h0A);
        do_read(IP, v); check("R7 later clear", v, 8'h08);

        // R6: held strobe clears only once; mid-strobe set survives
        do_set(8'h02);
        @(negedge clk); bus_addr = IP; rd_en = 1;
        #1 check("R6 cycle1", rd_data, 8'h0A);
        @(negedge clk); irq_set = 8'h02;
        #1 check("R6 cycle2 cleared", rd_data, 8'h08);
        @(negedge clk); irq_set = 8'h00;
        #1 check("R6 cycle3 set", rd_data, 8'h0A);
        @(negedge clk);
        #1 check("R6 no second clear", rd_data, 8'h0A);
        @(negedge clk); idle();
        do_read(IP, v); check("R6 new strobe", v, 8'h0A);
        do_read(IP, v); check("R6 new strobe cleared", v, 8'h08);

        // R8: mid-run reset
        do_write(IP, 8'h30);
        do_reset();
        reset_checks("R8 mid-run reset");

        done = 1'b1;
    end

    initial begin
        int n;
        n = 0;
        while (!done && n < 20000) begin
            @(posedge clk); n++;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule